// File: doc/BRIEF.md
# Spin-Table Release Controller

This block keeps a small boot table in registers, one 32-byte entry for each processor in a multiprocessor system. Secondary processors wait in a loop until boot software clears the hold bit in their entry. The block then raises a release for that processor and gives it its entry point, its argument and the bounds of a 64 MiB mapping window. Processor 0 is the primary and never waits, so its entry cannot be written. Entries of processors that are marked absent on the present-mask input are also protected.

Software reaches the table through a simple slave bus with byte, halfword and word accesses in big-endian order. Every request is acknowledged on the following cycle.

The access decoder sorts each request into one of four access classes:

| Class | Meaning |
| --- | --- |
| `ACC_IDLE` | No request, or a write of an unsupported size, which is dropped. |
| `ACC_READ` | A read of a legal size. |
| `ACC_WRITE` | A write of a legal size. |
| `ACC_FAULT` | A read of an unsupported size. |

A write leads to a release check when it is accepted. A write is accepted when it falls inside the window, does not target entry 0, and targets a processor that is present. The release check takes place in the same cycle as the accepted write. Its outcome, release or no release, is seen at the outputs on the next cycle.

Top module: `spin_release_ctrl`

## Requirements
- R1: After reset, every entry i reads start address = 1, argument = i and processor ID = i, with all other bytes zero. All release pulses are low, all per-processor release outputs are zero, and `rel_map_size` is 2^26.
- R2: Entry i starts at byte offset 32*i. Its fields are placed as follows:
  - bytes 0–7: start address
  - bytes 8–15: argument
  - bytes 16–19: reserved
  - bytes 20–23: processor ID
  - bytes 24–31: reserved

  Every multi-byte field is big-endian, with its most significant byte at the lowest offset.
- R3: `bus_size` encodes the access size as 0 = byte, 1 = halfword, 2 = word and 3 = unsupported. A write of 1, 2 or 4 bytes stores `bus_wdata` right-justified, placing its most significant byte at the addressed offset. A read returns the same layout in `bus_rdata`, right-justified, with the upper bits zero.
- R4: A write is discarded when it targets entry 0 or an entry whose `cpu_present` bit is 0. A discarded write stores nothing and releases nothing.
- R5: After each accepted write, bit 0 of the entry's start address is checked. If it is 0, `rel_pulse[i]` is high for exactly the one cycle that follows the write. At most one pulse is high at a time.
- R6: On a release of processor i, three outputs are loaded from the entry as it stands after the write. `rel_entry` slice i takes the start address masked to its low 26 bits. `rel_map_base` slice i takes the start address with those 26 bits cleared. `rel_arg` slice i takes the argument. All three keep their values until the next release of processor i.
- R7: On a release of processor i, the entry's processor ID field is set to i. This overrides any value the same write put there.
- R8: `bus_ready` is high in the cycle after each cycle in which `bus_req` is high, and low otherwise. `bus_rdata` and `bus_err` are valid in that cycle.
- R9: A read with size code 3 raises `bus_err` for one cycle and returns zero data. A write with size code 3 changes nothing and raises no error.
- R10: Accesses at offsets at or beyond 32*N are ignored. Bytes at those offsets read as zero.
- R11: Every accepted write checks the hold bit again, including writes to the argument, ID or reserved fields. A write that leaves the hold bit at 1 produces no pulse.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte offset into the window |
| bus_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 unsupported |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Read data, right-justified |
| bus_ready | output | 1 | Acknowledge, one cycle after the request |
| bus_err | output | 1 | Unsupported-size read |
| cpu_present | input | N_CPU | Present-processor mask |
| rel_pulse | output | N_CPU | One-cycle release per processor |
| rel_entry | output | 64*N_CPU | Entry point per processor |
| rel_arg | output | 64*N_CPU | Argument per processor |
| rel_map_base | output | 64*N_CPU | Mapping base per processor |
| rel_map_size | output | 64 | Mapping size (2^26) |

## Verification
The bench builds the block with N_CPU = 4 and BUS_AW = 8. This gives a 128-byte table that can be read back completely after every phase. Every byte, halfword-aligned and word-aligned offset is compared against a byte model kept in the bench. The 8-bit address also reaches offsets up to 255, so accesses beyond the window can be exercised.

Starting with processor 2 marked absent puts the discard rule under test together with the entry-0 rule. Releases are then driven through byte, halfword and word writes to several fields. This covers the override of the processor ID and the repeated check of the hold bit.

// File: rtl/spin_rel_pkg.sv
package spin_rel_pkg;
    localparam int ENTRY_BYTES = 32;
    localparam int ENTRY_SHIFT = 5;
    localparam int MAP_BITS    = 26;
    localparam int OFF_PID     = 20;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE,
        ACC_FAULT
    } acc_kind_e;

    function automatic logic [2:0] size_bytes(acc_size_e s);
        logic [2:0] n;
        unique case (s)
            SZ_BYTE: n = 3'd1;
            SZ_HALF: n = 3'd2;
            SZ_WORD: n = 3'd4;
            SZ_BAD:  n = 3'd0;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/spin_table_store.sv
module spin_table_store
    import spin_rel_pkg::*;
#(
    parameter int N_CPU = 32,
    parameter int WIN   = N_CPU * ENTRY_BYTES,
    parameter int AW    = $clog2(WIN),
    parameter int IW    = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [2:0]    wr_nbytes,
    input  logic [31:0]   wr_data,
    input  logic [IW-1:0] view_idx,
    output logic [63:0]   view_start,
    output logic [63:0]   view_arg,
    input  logic          pid_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [2:0]    rd_nbytes,
    output logic [31:0]   rd_data
);
    logic [7:0] mem [WIN];

    function automatic logic [7:0] lane(logic [31:0] d, logic [2:0] n, int k);
        return 8'(d >> (8 * (int'(n) - 1 - k)));
    endfunction

    // Entry fields as they will stand after this cycle's write
    always_comb begin
        logic [127:0] acc;
        acc = '0;
        for (int j = 0; j < 16; j++) begin
            int a;
            logic [7:0] b;
            a = int'(view_idx) * ENTRY_BYTES + j;
            b = (a < WIN) ? mem[AW'(a)] : 8'h00;
            if (wr_en && a >= int'(wr_addr) && a < int'(wr_addr) + int'(wr_nbytes))
                b = lane(wr_data, wr_nbytes, a - int'(wr_addr));
            acc = {acc[119:0], b};
        end
        view_start = acc[127:64];
        view_arg   = acc[63:0];
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < int'(rd_nbytes)) begin
                if (int'(rd_addr) + k < WIN)
                    rd_data = {rd_data[23:0], mem[rd_addr + AW'(k)]};
                else
                    rd_data = {rd_data[23:0], 8'h00};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < N_CPU; e++) begin
                for (int b = 0; b < ENTRY_BYTES; b++)
                    mem[AW'(e * ENTRY_BYTES + b)] <= 8'h00;
                mem[AW'(e * ENTRY_BYTES + 7)]  <= 8'h01;
                mem[AW'(e * ENTRY_BYTES + 15)] <= 8'(e);
                mem[AW'(e * ENTRY_BYTES + 23)] <= 8'(e);
            end
        end else begin
            if (wr_en) begin
                for (int k = 0; k < 4; k++)
                    if (k < int'(wr_nbytes) && int'(wr_addr) + k < WIN)
                        mem[wr_addr + AW'(k)] <= lane(wr_data, wr_nbytes, k);
            end
            // Release overrides the ID field last
            if (pid_en) begin
                for (int k = 0; k < 4; k++)
                    mem[AW'(int'(view_idx) * ENTRY_BYTES + OFF_PID + k)] <=
                        8'((32'(view_idx)) >> (8 * (3 - k)));
            end
        end
    end
endmodule

// File: rtl/spin_release_bank.sv
module spin_release_bank
    import spin_rel_pkg::*;
#(
    parameter int N_CPU = 32,
    parameter int IW    = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic [IW-1:0]       fire_idx,
    input  logic [63:0]         start,
    input  logic [63:0]         arg,
    output logic [N_CPU-1:0]    pulse,
    output logic [64*N_CPU-1:0] entry_o,
    output logic [64*N_CPU-1:0] arg_o,
    output logic [64*N_CPU-1:0] base_o
);
    localparam logic [63:0] OFS_MASK = (64'd1 << MAP_BITS) - 64'd1;

    for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
        logic hit;
        assign hit = fire && (int'(fire_idx) == g);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pulse[g]           <= 1'b0;
                entry_o[64*g +: 64] <= '0;
                arg_o[64*g +: 64]   <= '0;
                base_o[64*g +: 64]  <= '0;
            end else begin
                pulse[g] <= hit;
                if (hit) begin
                    entry_o[64*g +: 64] <= start & OFS_MASK;
                    base_o[64*g +: 64]  <= start & ~OFS_MASK;
                    arg_o[64*g +: 64]   <= arg;
                end
            end
        end

        // R6: release values hold between this processor's releases
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !pulse[g] |-> ($stable(entry_o[64*g +: 64]) && $stable(base_o[64*g +: 64])
                           && $stable(arg_o[64*g +: 64])));
    end
endmodule

// File: rtl/spin_release_ctrl.sv
module spin_release_ctrl
    import spin_rel_pkg::*;
#(
    parameter int N_CPU  = 32,
    parameter int BUS_AW = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [1:0]          bus_size,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_ready,
    output logic                bus_err,
    input  logic [N_CPU-1:0]    cpu_present,
    output logic [N_CPU-1:0]    rel_pulse,
    output logic [64*N_CPU-1:0] rel_entry,
    output logic [64*N_CPU-1:0] rel_arg,
    output logic [64*N_CPU-1:0] rel_map_base,
    output logic [63:0]         rel_map_size
);
    localparam int WIN = N_CPU * ENTRY_BYTES;
    localparam int AW  = $clog2(WIN);
    localparam int IW  = (N_CPU > 1) ? $clog2(N_CPU) : 1;

    acc_size_e     sz;
    acc_kind_e     kind;
    logic          in_win, wr_ok, fire;
    logic [IW-1:0] idx;
    logic [2:0]    nbytes;
    logic [63:0]   v_start, v_arg;
    logic [31:0]   rd_data;

    assign sz     = acc_size_e'(bus_size);
    assign nbytes = size_bytes(sz);
    assign in_win = int'(bus_addr) < WIN;
    assign idx    = bus_addr[ENTRY_SHIFT +: IW];

    always_comb begin
        kind = ACC_IDLE;
        if (bus_req) begin
            unique case ({bus_we, sz == SZ_BAD})
                2'b00: kind = ACC_READ;
                2'b01: kind = ACC_FAULT;
                2'b10: kind = ACC_WRITE;
                2'b11: kind = ACC_IDLE;
            endcase
        end
    end

    assign wr_ok = (kind == ACC_WRITE) && in_win && (idx != '0) && cpu_present[idx];
    assign fire  = wr_ok && !v_start[0];

    spin_table_store #(.N_CPU(N_CPU)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_ok), .wr_addr(bus_addr[AW-1:0]), .wr_nbytes(nbytes), .wr_data(bus_wdata),
        .view_idx(idx), .view_start(v_start), .view_arg(v_arg), .pid_en(fire),
        .rd_addr(bus_addr[AW-1:0]), .rd_nbytes(nbytes), .rd_data(rd_data)
    );

    spin_release_bank #(.N_CPU(N_CPU)) u_bank (
        .clk(clk), .rst_n(rst_n), .fire(fire), .fire_idx(idx),
        .start(v_start), .arg(v_arg), .pulse(rel_pulse),
        .entry_o(rel_entry), .arg_o(rel_arg), .base_o(rel_map_base)
    );

    assign rel_map_size = 64'd1 << MAP_BITS;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_req;
            bus_err   <= (kind == ACC_FAULT);
            bus_rdata <= (kind == ACC_READ && in_win) ? rd_data : 32'h0;
        end
    end

    p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ready);
    p_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_ready);
    p_err_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_req && !bus_we && bus_size == 2'd3));
    p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == 32'h0));
    p_boot_cpu_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_pulse[0]);
    p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_pulse));
    p_pulse_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_pulse) |-> $past(bus_req && bus_we));
endmodule

// File: tb/spin_release_ctrl_tb.sv
`timescale 1ns/1ps
module spin_release_ctrl_tb;
    localparam int N = 4;
    localparam int BAW = 8;
    localparam int WIN = N * 32;
    localparam logic [63:0] MASK = (64'd1 << 26) - 64'd1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           bus_req = 1'b0, bus_we = 1'b0;
    logic [BAW-1:0] bus_addr = '0;
    logic [1:0]     bus_size = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           bus_ready, bus_err;
    logic [N-1:0]   cpu_present = 4'b1011;
    logic [N-1:0]   rel_pulse;
    logic [64*N-1:0] rel_entry, rel_arg, rel_map_base;
    logic [63:0]    rel_map_size;

    spin_release_ctrl #(.N_CPU(N), .BUS_AW(BAW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_err(bus_err), .cpu_present(cpu_present),
        .rel_pulse(rel_pulse), .rel_entry(rel_entry), .rel_arg(rel_arg),
        .rel_map_base(rel_map_base), .rel_map_size(rel_map_size)
    );

    int checks = 0, fails = 0;
    logic [7:0]  m [WIN];
    logic [63:0] e_entry [N], e_arg [N], e_base [N];

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int nb_of(int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
    endfunction

    function automatic logic [63:0] m_field(int base, int nb);
        logic [63:0] v = '0;
        for (int k = 0; k < nb; k++)
            v = (v << 8) | ((base + k < WIN) ? 64'(m[base + k]) : 64'h0);
        return v;
    endfunction

    task automatic chk_outs(string req);
        for (int i = 0; i < N; i++) begin
            chk(req, "entry", rel_entry[64*i +: 64], e_entry[i]);
            chk(req, "arg", rel_arg[64*i +: 64], e_arg[i]);
            chk(req, "base", rel_map_base[64*i +: 64], e_base[i]);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the acknowledge
    task automatic do_write(string req, int addr, int sz, logic [31:0] data);
        int nb = nb_of(sz);
        int idx = addr / 32;
        logic [N-1:0] exp_p = '0;
        if (nb > 0 && addr < WIN && idx != 0 && cpu_present[idx]) begin
            for (int k = 0; k < nb; k++)
                if (addr + k < WIN) m[addr + k] = 8'(data >> (8 * (nb - 1 - k)));
            if (m_field(idx * 32, 8) % 2 == 0) begin
                logic [63:0] st = m_field(idx * 32, 8);
                exp_p[idx] = 1'b1;
                for (int k = 0; k < 4; k++) m[idx * 32 + 20 + k] = 8'(idx >> (8 * (3 - k)));
                e_entry[idx] = st & MASK;
                e_base[idx]  = st & ~MASK;
                e_arg[idx]   = m_field(idx * 32 + 8, 8);
            end
        end
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = BAW'(addr);
        bus_size = 2'(sz); bus_wdata = data;
        @(negedge clk);
        bus_req = 1'b0;
        chk("R8", "write ready", 64'(bus_ready), 64'd1);
        chk("R9", "write err", 64'(bus_err), 64'd0);
        chk(req, "pulse", 64'(rel_pulse), 64'(exp_p));
        chk_outs(req);
    endtask

    task automatic do_read(string req, int addr, int sz);
        int nb = nb_of(sz);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = BAW'(addr); bus_size = 2'(sz);
        @(negedge clk);
        bus_req = 1'b0;
        chk("R8", "read ready", 64'(bus_ready), 64'd1);
        chk(nb == 0 ? "R9" : req, "read err", 64'(bus_err), (nb == 0) ? 64'd1 : 64'd0);
        chk(req, $sformatf("rdata @%0d/%0d", addr, sz), 64'(bus_rdata), m_field(addr, nb));
        chk("R5", "read no pulse", 64'(rel_pulse), 64'd0);
    endtask

    task automatic sweep(string req);
        for (int a = 0; a < WIN; a++) do_read(req, a, 0);
        for (int a = 0; a < WIN; a += 2) do_read(req, a, 1);
        for (int a = 0; a < WIN; a += 4) do_read(req, a, 2);
    endtask

    initial begin
        #(4 * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            for (int b = 0; b < 32; b++) m[i * 32 + b] = 8'h00;
            m[i * 32 + 7] = 8'h01; m[i * 32 + 15] = 8'(i); m[i * 32 + 23] = 8'(i);
            e_entry[i] = '0; e_arg[i] = '0; e_base[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "pulses", 64'(rel_pulse), 64'd0);
        chk("R1", "ready", 64'(bus_ready), 64'd0);
        chk("R1", "map size", rel_map_size, 64'd1 << 26);
        chk_outs("R1");
        sweep("R1");
        // R2 R3 R11 R4: reserved/arg writes with hold set, entries 0 and 2 protected
        for (int i = 0; i < N; i++) begin
            do_write("R11", i * 32 + 16, 2, {8'(i), 8'hA5, 8'h5A, 8'(3 * i)});
            do_write("R3", i * 32 + 24, 1, 32'(16'hC0DE + i));
            do_write("R3", i * 32 + 26, 1, 32'h00007E81);
            for (int b = 28; b < 32; b++) do_write("R3", i * 32 + b, 0, 32'(b * 7 + i));
            do_write("R11", i * 32 + 14, 1, 32'h0000BEEF);
        end
        sweep("R3");
        // R5 R6: release of processor 1 through a final byte write
        do_write("R6", 32 + 8, 2, 32'hAABBCCDD);
        do_write("R6", 32 + 12, 2, 32'h11223344);
        do_write("R11", 32 + 0, 2, 32'h12345678);
        do_write("R11", 32 + 4, 2, 32'h9ABCDEF1);
        do_write("R5", 32 + 7, 0, 32'h000000F0);
        // R7: ID write while hold clear re-releases and ID returns to 1
        do_write("R7", 32 + 20, 2, 32'h0000DEAD);
        do_read("R7", 32 + 20, 2);
        // R11: argument change re-releases with new argument
        do_write("R11", 32 + 14, 1, 32'h00005555);
        // R6: setting hold again keeps outputs
        do_write("R6", 32 + 7, 0, 32'h00000001);
        // R4: absent processor 2 and primary 0 ignore clearing the hold bit
        do_write("R4", 64 + 7, 0, 32'h00000000);
        do_write("R4", 0 + 7, 0, 32'h00000000);
        do_read("R4", 64 + 4, 2);
        do_read("R4", 4, 2);
        // R5: processor 3 released by halfword write
        do_write("R5", 96 + 0, 1, 32'h0000F00D);
        do_write("R5", 96 + 6, 1, 32'h0000CAFE);
        // Processor 2 now present
        cpu_present = 4'b1111;
        do_write("R5", 64 + 4, 2, 32'h07FFFFFE);
        // R9: unsupported sizes
        do_read("R9", 40, 3);
        do_write("R9", 32 + 24, 3, 32'hFFFFFFFF);
        // R10: outside the window
        do_write("R10", WIN, 2, 32'hFFFFFFFF);
        do_write("R10", 200, 0, 32'h00000000);
        do_read("R10", WIN, 2);
        do_read("R10", 252, 1);
        do_read("R10", WIN - 2, 2);
        sweep("R2");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule